// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs a microcontroller-style external memory bus on which one byte-wide port first carries the low address byte and then the data byte, while a second port carries the high address byte. A core hands it one access at a time: an instruction fetch at a 16-bit program counter, or a data load or store that is addressed either by a 16-bit data pointer or by an 8-bit register pointer. The block works out whether the access leaves the chip, runs the bus cycle with an address latch pulse and one of three active-low strobes, and returns a one-byte response to the core.

A fetch stays on chip unless the external-access input is high or the program counter is above 0x1FFF. A fetch that stays on chip produces no bus activity and is answered at once, flagged as internal. The on-chip memory itself is outside this block. When no bus cycle is running, the high address port mirrors the port 2 register value from the core and the low port is released.

Requests and responses use valid/ready. Only one access is outstanding at a time: `req_ready` is high only while the bus is idle and no response is waiting. A response stays valid, with stable data, until the core takes it with `rsp_ready`. While it waits, the block accepts no new request.

Top module: `xbus_ctrl`

## Requirements
- R1: A fetch (`req_kind` 0) goes on the bus when `ext_force` is 1 or `req_pc` > 0x1FFF. Otherwise there is no address latch pulse and no strobe, and the response comes the cycle after acceptance with `rsp_internal`=1 and `rsp_data`=0.
- R2: An external fetch presents address `req_pc`, high byte on `p2_out` and low byte on `p0_out`. Only `prog_rd_n` strobes, and the response returns the byte on `p0_in` with `rsp_internal`=0.
- R3: A data access with `req_wide`=1 presents `req_dptr` as its address, high byte on `p2_out` and low byte on `p0_out`.
- R4: A data access with `req_wide`=0 presents `p2_sfr` (as it was at acceptance) on `p2_out` and `req_reg` on `p0_out`.
- R5: A read (`req_kind` 1, or 3, which is treated as a read) strobes only `data_rd_n`, keeps `p0_oe` low while the strobe is low, and returns the `p0_in` byte captured while the strobe is still low.
- R6: A write (`req_kind` 2) strobes only `data_wr_n`. `p0_out`=`req_wdata` with `p0_oe`=1 from the phase before the strobe falls through the phase after it rises. The response carries `rsp_data`=0.
- R7: Each bus cycle starts with `addr_latch` high while `p0_out` drives the low address with `p0_oe`=1. The address stays on port 0 for one phase after `addr_latch` falls. No strobe is low while `addr_latch` is high.
- R8: At most one of the three active-low strobes is low at any time, and all are high after reset.
- R9: Every phase lasts `PH_CYC` clocks, so `addr_latch` is high and the strobe is low for exactly `PH_CYC` clocks each.
- R10: `req_ready` is 1 only when idle, so one access is outstanding at a time. A valid response holds `rsp_valid` and `rsp_data` until `rsp_ready` is 1.
- R11: Outside a bus cycle `p0_oe`=0 and `p2_out` follows `p2_sfr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_wide | input | 1 | Data access uses the 16-bit pointer |
| req_pc | input | 16 | Program counter for fetches |
| req_dptr | input | 16 | 16-bit data pointer |
| req_reg | input | 8 | 8-bit register pointer |
| req_wdata | input | 8 | Write data |
| ext_force | input | 1 | Forces all fetches onto the bus |
| p2_sfr | input | 8 | Port 2 register value held by the core |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Core takes the response |
| rsp_data | output | 8 | Fetched or read byte, 0 otherwise |
| rsp_internal | output | 1 | Fetch was served on chip |
| p0_out | output | 8 | Port 0 drive value |
| p0_oe | output | 1 | Port 0 output enable |
| p0_in | input | 8 | Port 0 pin value |
| p2_out | output | 8 | Port 2 drive value |
| addr_latch | output | 1 | Address latch enable, active high |
| prog_rd_n | output | 1 | Program memory read strobe, active low |
| data_rd_n | output | 1 | Data memory read strobe, active low |
| data_wr_n | output | 1 | Data memory write strobe, active low |

## Verification
A wrong phase state shows on the pins within one phase. It appears as a strobe that overlaps the address latch pulse or another strobe, as an address latch pulse or strobe of the wrong width, or as port 0 released while the write strobe is low. A wrong route decision or a wrong high-byte source shows at the falling edge of the address latch pulse, as an unexpected address or as a bus cycle where none should be. A wrong capture point or response hand-off shows when the response is consumed, through a byte that differs from the memory model or through data that changes while the core stalls.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  parameter int unsigned XB_AW = 16;
  parameter int unsigned XB_DW = 8;
  localparam int unsigned XB_HW = XB_AW - XB_DW;

  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_READ  = 2'd1,
    K_WRITE = 2'd2,
    K_RDALT = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_HOLD, PH_SETUP, PH_STRB, PH_RECOV, PH_DONE
  } phase_e;
endpackage

// File: rtl/xbus_route.sv
module xbus_route
  import xbus_pkg::*;
#(
  parameter logic [XB_AW-1:0] ROM_LIMIT = 16'h1FFF
) (
  input  kind_e            kind,
  input  logic             wide,
  input  logic [XB_AW-1:0] pc,
  input  logic [XB_AW-1:0] dptr,
  input  logic [XB_DW-1:0] rreg,
  input  logic [XB_HW-1:0] sfr_hi,
  input  logic             ext_force,
  output logic             go_ext,
  output logic [XB_AW-1:0] addr
);
  always_comb begin
    if (kind == K_FETCH) begin
      go_ext = ext_force || (pc > ROM_LIMIT);
      addr   = pc;
    end else begin
      go_ext = 1'b1;
      addr   = wide ? dptr : {sfr_hi, rreg};
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned PH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_ext,
  input  kind_e            start_kind,
  input  logic [XB_AW-1:0] start_addr,
  input  logic [XB_DW-1:0] start_wdata,
  input  logic [XB_DW-1:0] p0_in,
  input  logic             rsp_ready,
  output logic             idle,
  output logic             bus_act,
  output logic [XB_HW-1:0] addr_hi,
  output logic [XB_DW-1:0] p0_out,
  output logic             p0_oe,
  output logic             ale,
  output logic             prog_rd_n,
  output logic             data_rd_n,
  output logic             data_wr_n,
  output logic             rsp_valid,
  output logic [XB_DW-1:0] rsp_data,
  output logic             rsp_internal
);
  localparam int unsigned CW = $clog2(PH_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PH_CYC - 1);

  phase_e           st;
  logic [CW-1:0]    cnt;
  kind_e            kind_q;
  logic [XB_AW-1:0] addr_q;
  logic [XB_DW-1:0] wdata_q;
  logic             is_wr, is_fetch, ph_end;

  assign is_wr    = (kind_q == K_WRITE);
  assign is_fetch = (kind_q == K_FETCH);
  assign ph_end   = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= PH_IDLE;
      cnt          <= '0;
      kind_q       <= K_FETCH;
      addr_q       <= '0;
      wdata_q      <= '0;
      rsp_data     <= '0;
      rsp_internal <= 1'b0;
    end else begin
      unique case (st)
        PH_IDLE: if (start) begin
          kind_q       <= start_kind;
          addr_q       <= start_addr;
          wdata_q      <= start_wdata;
          rsp_data     <= '0;
          rsp_internal <= !start_ext;
          cnt          <= '0;
          st           <= start_ext ? PH_ADDR : PH_DONE;
        end
        PH_ADDR, PH_HOLD, PH_SETUP, PH_STRB, PH_RECOV: begin
          cnt <= ph_end ? '0 : cnt + 1'b1;
          if (ph_end) begin
            if (st == PH_STRB && !is_wr) rsp_data <= p0_in;
            st <= phase_e'(st + 3'd1);
          end
        end
        PH_DONE: if (rsp_ready) st <= PH_IDLE;
        default: st <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    idle      = (st == PH_IDLE);
    rsp_valid = (st == PH_DONE);
    bus_act   = (st != PH_IDLE) && (st != PH_DONE);
    addr_hi   = addr_q[XB_AW-1:XB_DW];
    ale       = (st == PH_ADDR);
    p0_oe     = (st == PH_ADDR) || (st == PH_HOLD) ||
                (is_wr && (st == PH_SETUP || st == PH_STRB || st == PH_RECOV));
    p0_out    = (st == PH_ADDR || st == PH_HOLD) ? addr_q[XB_DW-1:0] :
                (is_wr ? wdata_q : '0);
    prog_rd_n = !((st == PH_STRB) && is_fetch);
    data_rd_n = !((st == PH_STRB) && !is_fetch && !is_wr);
    data_wr_n = !((st == PH_STRB) && is_wr);
  end

  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~prog_rd_n, ~data_rd_n, ~data_wr_n}) <= 1);
  a_r7_ale_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (prog_rd_n && data_rd_n && data_wr_n && p0_oe));
  a_r6_data_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_wr_n) |-> ($past(p0_oe) && $past(p0_out) == p0_out));
  a_r6_data_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_wr_n) |-> (p0_oe && $past(p0_out) == p0_out));
  a_r5_rd_released: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd_n |-> !p0_oe);
  a_r1_internal_quick: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_ext) |=> (rsp_valid && rsp_internal && !ale));
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!p0_oe && !ale));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned      PH_CYC    = 2,
  parameter logic [XB_AW-1:0] ROM_LIMIT = 16'h1FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic             req_wide,
  input  logic [XB_AW-1:0] req_pc,
  input  logic [XB_AW-1:0] req_dptr,
  input  logic [XB_DW-1:0] req_reg,
  input  logic [XB_DW-1:0] req_wdata,
  input  logic             ext_force,
  input  logic [XB_HW-1:0] p2_sfr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [XB_DW-1:0] rsp_data,
  output logic             rsp_internal,
  output logic [XB_DW-1:0] p0_out,
  output logic             p0_oe,
  input  logic [XB_DW-1:0] p0_in,
  output logic [XB_HW-1:0] p2_out,
  output logic             addr_latch,
  output logic             prog_rd_n,
  output logic             data_rd_n,
  output logic             data_wr_n
);
  kind_e            kind;
  logic             go_ext, idle, bus_act, start;
  logic [XB_AW-1:0] addr;
  logic [XB_HW-1:0] addr_hi;

  assign kind      = kind_e'(req_kind);
  assign req_ready = idle;
  assign start     = req_valid && idle;
  assign p2_out    = bus_act ? addr_hi : p2_sfr;

  xbus_route #(.ROM_LIMIT(ROM_LIMIT)) route_i (
    .kind(kind), .wide(req_wide), .pc(req_pc), .dptr(req_dptr),
    .rreg(req_reg), .sfr_hi(p2_sfr), .ext_force(ext_force),
    .go_ext(go_ext), .addr(addr)
  );

  xbus_seq #(.PH_CYC(PH_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ext(go_ext),
    .start_kind(kind), .start_addr(addr), .start_wdata(req_wdata),
    .p0_in(p0_in), .rsp_ready(rsp_ready), .idle(idle), .bus_act(bus_act),
    .addr_hi(addr_hi), .p0_out(p0_out), .p0_oe(p0_oe), .ale(addr_latch),
    .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_internal(rsp_internal)
  );

  a_r11_p2_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !rsp_valid) |-> (p2_out == p2_sfr));
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int PH = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wide = 1'b0, ext_force = 1'b0, rsp_ready = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [15:0] req_pc = '0, req_dptr = '0;
  logic [7:0] req_reg = '0, req_wdata = '0, p2_sfr = 8'h00, p0_in;
  logic req_ready, rsp_valid, rsp_internal, p0_oe, addr_latch;
  logic prog_rd_n, data_rd_n, data_wr_n;
  logic [7:0] rsp_data, p0_out, p2_out;

  always #(CLK_P/2) clk = ~clk;

  xbus_ctrl #(.PH_CYC(PH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_wide(req_wide), .req_pc(req_pc),
    .req_dptr(req_dptr), .req_reg(req_reg), .req_wdata(req_wdata),
    .ext_force(ext_force), .p2_sfr(p2_sfr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_internal(rsp_internal),
    .p0_out(p0_out), .p0_oe(p0_oe), .p0_in(p0_in), .p2_out(p2_out),
    .addr_latch(addr_latch), .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n),
    .data_wr_n(data_wr_n)
  );

  typedef struct { logic [15:0] a; logic [1:0] k; logic [7:0] w; } bus_t;
  bus_t busq[$];
  logic [8:0] rspq[$];
  bus_t cur;
  int checks = 0, errors = 0, exp_ext = 0, ale_rises = 0;
  int ale_w = 0, st_w = 0;
  logic prev_ale = 0, prev_oe = 0, prev_hold = 0;
  logic [7:0] prev_p0 = '0, prev_data = '0;
  logic [15:0] lat_a = '0;
  bit done = 0;

  function automatic logic [7:0] pmem(logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'hC3;
  endfunction
  function automatic logic [7:0] dmem(logic [15:0] a);
    return a[15:8] + a[7:0] + 8'h5A;
  endfunction

  assign p0_in = !prog_rd_n ? pmem(lat_a) : (!data_rd_n ? dmem(lat_a) : 8'h00);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // response back-pressure pattern
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #2;
      n++;
      rsp_ready = (n % 4) != 1;
    end
  end

  // bus and response monitor
  always @(negedge clk) if (rst_n) begin
    logic [2:0] lowv, expv;
    if (addr_latch && !prev_ale) ale_rises++;
    if (addr_latch) ale_w++;
    else if (prev_ale) begin
      chk(ale_w == PH, "R9 ale width", ale_w, PH);
      lat_a = {p2_out, p0_out};
      chk(busq.size() > 0, "R1 unexpected bus cycle", busq.size(), 1);
      if (busq.size() > 0) begin
        cur = busq.pop_front();
        chk(p0_oe && lat_a == cur.a, "R2/R3/R4/R7 address held after latch", lat_a, cur.a);
      end
      ale_w = 0;
    end
    lowv = {!prog_rd_n, !data_rd_n, !data_wr_n};
    expv = (cur.k == 2'd0) ? 3'b100 : ((cur.k == 2'd2) ? 3'b001 : 3'b010);
    if ($countones(lowv) > 1) chk(0, "R8 strobe overlap", lowv, expv);
    if (lowv != 0) begin
      if (st_w == 0) begin
        chk(lowv == expv && !addr_latch, "R2/R5/R6 strobe choice", lowv, expv);
        if (cur.k == 2'd2)
          chk(prev_oe && prev_p0 == cur.w, "R6 data before strobe", prev_p0, cur.w);
      end
      if (!data_wr_n) chk(p0_oe && p0_out == cur.w, "R6 data during strobe", p0_out, cur.w);
      if (!data_rd_n) chk(!p0_oe, "R5 port released on read", p0_oe, 0);
      st_w++;
    end else if (st_w != 0) begin
      chk(st_w == PH, "R9 strobe width", st_w, PH);
      if (cur.k == 2'd2)
        chk(p0_oe && p0_out == cur.w, "R6 data after strobe", p0_out, cur.w);
      st_w = 0;
    end
    if (prev_hold)
      chk(rsp_valid && rsp_data == prev_data, "R10 response held", rsp_data, prev_data);
    if (rsp_valid && rsp_ready) begin
      logic [8:0] e;
      chk(rspq.size() > 0, "R10 extra response", rspq.size(), 1);
      if (rspq.size() > 0) begin
        e = rspq.pop_front();
        chk({rsp_internal, rsp_data} == e, "R1/R2/R5/R6 response", {rsp_internal, rsp_data}, e);
      end
    end
    prev_hold = rsp_valid && !rsp_ready;
    prev_data = rsp_data;
    prev_ale = addr_latch;
    prev_oe = p0_oe;
    prev_p0 = p0_out;
  end

  task automatic do_req(logic [1:0] k, logic wide, logic [15:0] pc,
                        logic [15:0] dp, logic [7:0] rg, logic [7:0] wd);
    bit ext;
    logic [15:0] a;
    while (!req_ready) begin @(posedge clk); #2; end
    ext = (k != 2'd0) || ext_force || (pc > 16'h1FFF);
    a = (k == 2'd0) ? pc : (wide ? dp : {p2_sfr, rg});
    if (ext) begin
      busq.push_back('{a: a, k: k, w: wd});
      exp_ext++;
    end
    if (!ext) rspq.push_back({1'b1, 8'h00});
    else if (k == 2'd2) rspq.push_back({1'b0, 8'h00});
    else if (k == 2'd0) rspq.push_back({1'b0, pmem(a)});
    else rspq.push_back({1'b0, dmem(a)});
    req_kind = k; req_wide = wide; req_pc = pc; req_dptr = dp;
    req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    chk(!req_ready, "R10 one outstanding", req_ready, 0);
  endtask

  task automatic drain();
    while (rspq.size() != 0 || !req_ready) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(prog_rd_n && data_rd_n && data_wr_n && !addr_latch, "R8 reset strobes", {prog_rd_n, data_rd_n, data_wr_n}, 3'b111);
    chk(!p0_oe && !rsp_valid, "R11 reset port release", p0_oe, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(req_ready, "R10 ready after reset", req_ready, 1);
    p2_sfr = 8'h9C;
    // R1 routing boundary
    do_req(2'd0, 0, 16'h1FFF, 0, 0, 0);
    do_req(2'd0, 0, 16'h2000, 0, 0, 0);
    do_req(2'd0, 0, 16'h0000, 0, 0, 0);
    do_req(2'd0, 0, 16'hFFFF, 0, 0, 0);
    ext_force = 1'b1;
    do_req(2'd0, 0, 16'h0123, 0, 0, 0);
    ext_force = 1'b0;
    // R3/R4/R5 reads
    do_req(2'd1, 1, 16'hBEEF, 16'hA55A, 8'h00, 0);
    do_req(2'd1, 0, 16'h0000, 16'hFFFF, 8'h34, 0);
    do_req(2'd3, 1, 16'h0000, 16'h1234, 8'h00, 0);
    // R6 writes
    do_req(2'd2, 1, 16'h0000, 16'h4321, 8'h00, 8'hE7);
    p2_sfr = 8'h01;
    do_req(2'd2, 0, 16'h0000, 16'h0000, 8'hFE, 8'h18);
    for (int i = 0; i < 12; i++) begin
      p2_sfr = 8'(i * 37);
      do_req(2'(i % 3), i[0], 16'(16'h1F00 + i * 40), 16'(i * 4099), 8'(i * 11), 8'(i * 29 + 1));
    end
    drain();
    chk(ale_rises == exp_ext, "R1 bus cycle count", ale_rises, exp_ext);
    p2_sfr = 8'h6B;
    @(posedge clk); #2;
    chk(p2_out == 8'h6B && !p0_oe, "R11 idle mirrors sfr", p2_out, 8'h6B);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule